// File: doc/BRIEF.md
# Receive Frame Length Statistics Counters

This block accumulates statistics for good received frames. Each frame arrives as a single-cycle pulse together with its data length, which excludes the four frame check sequence bytes. The block adds those four bytes back to obtain the on-wire length. It then sorts the frame into one of six length bins, increments a total frame counter and adds the on-wire length to a wide octet accumulator. Every counter saturates and never wraps.

A second copy of the frame total and a second copy of the octet total are held in good-frame shadow registers. These copies always equal the totals. All values are read through a registered read port addressed by a small word index. The receive path signals every frame it has accepted, and a management agent polls the port. A single-cycle update latency means a frame pulse never stalls. No state machine is used: each frame is handled in one cycle by a pipeline-free datapath.

Top module: `rx_len_stats`

## Requirements
- R1: A frame whose on-wire length (data length + 4) is exactly 64 increments bin 0 (read address 0) and no other bin.
- R2: On-wire lengths 65..127, 128..255, 256..511, 512..1023 and 1024 or more increment bins 1, 2, 3, 4 and 5 (read addresses 1..5) respectively, with each edge value landing in the bin stated.
- R3: A frame with on-wire length below 64 increments no bin but is still counted in the frame total and the octet total.
- R4: Every frame pulse increments the frame total (address 6). The good-frame register (address 7) equals the frame total at all times.
- R5: The octet total grows by data length + 4 per frame. Its low 32 bits read at address 8 and its upper bits at address 9, and a carry out of the low half propagates into the upper half.
- R6: When an octet addition carries out of the top of the octet total, the total is held at all ones.
- R7: Bin and frame counters stop at their all-ones value and stay there on further frames.
- R8: The good-octet low and high registers (addresses 10 and 11) equal the octet total halves at all times.
- R9: A frame pulse is reflected in a read issued one cycle later. A read issued in the same cycle as a frame pulse returns the value from before that frame.
- R10: A read request returns data with rd_vld high exactly one cycle later. Addresses 12..15 read as zero.
- R11: After reset every counter reads zero and rd_vld is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_vld | input | 1 | One good frame accepted this cycle |
| frm_len | input | LEN_W | Frame data length in bytes, without check sequence |
| rd_en | input | 1 | Read request |
| rd_addr | input | 4 | Read word index |
| rd_vld | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | 32 | Read data, zero-extended |

## Verification
A frame pulse sampled at a rising edge changes the counters at that same edge, so a read launched on the next cycle returns the new value. Read data is registered, so rd_data and rd_vld are due at the edge after rd_en. The bench drives inputs on falling edges and samples rd_data on the following falling edge, half a cycle after the result settles. For a read that coincides with a frame, the same sample point must still show the value from before the frame. The saturation and carry cases use a narrow-counter, 34-bit-octet instance, which reaches its limits within the run time.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
    localparam int NUM_BKT   = 6;
    localparam int FCS_BYTES = 4;
    localparam int ADDR_W    = 4;
    localparam int DATA_W    = 32;

    typedef enum logic [ADDR_W-1:0] {
        A_BKT64    = 4'd0,
        A_BKT127   = 4'd1,
        A_BKT255   = 4'd2,
        A_BKT511   = 4'd3,
        A_BKT1023  = 4'd4,
        A_BKTBIG   = 4'd5,
        A_TOTPKT   = 4'd6,
        A_GOODPKT  = 4'd7,
        A_TOTOCTLO = 4'd8,
        A_TOTOCTHI = 4'd9,
        A_GDOCTLO  = 4'd10,
        A_GDOCTHI  = 4'd11
    } reg_addr_e;

    // Lower edge of each bin in on-wire bytes; index NUM_BKT is a sentinel.
    function automatic int unsigned bkt_floor(input int idx);
        case (idx)
            0:       return 64;
            1:       return 65;
            2:       return 128;
            3:       return 256;
            4:       return 512;
            5:       return 1024;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction
endpackage

// File: rtl/rxs_classify.sv
module rxs_classify
    import rxs_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic [LEN_W-1:0]   data_len,
    output logic [NUM_BKT-1:0] bkt_hit
);
    localparam int WIRE_W = LEN_W + 1;

    logic [WIRE_W-1:0] wire_len;

    assign wire_len = WIRE_W'(data_len) + WIRE_W'(FCS_BYTES);

    for (genvar g = 0; g < NUM_BKT; g++) begin : g_bin
        localparam logic [WIRE_W-1:0] FLOOR = WIRE_W'(bkt_floor(g));
        if (g == NUM_BKT - 1) begin : g_top
            assign bkt_hit[g] = (wire_len >= FLOOR);
        end else begin : g_mid
            localparam logic [WIRE_W-1:0] CEIL = WIRE_W'(bkt_floor(g + 1));
            assign bkt_hit[g] = (wire_len >= FLOOR) && (wire_len < CEIL);
        end
    end
endmodule

// File: rtl/rxs_sat_cnt.sv
module rxs_sat_cnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cnt_nxt
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_comb begin
        cnt_nxt = cnt;
        if (inc && (cnt != TOP)) begin
            cnt_nxt = cnt + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            cnt <= cnt_nxt;
        end
    end

    // R7
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == TOP) |=> (cnt == TOP));

    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && (cnt != TOP)) |=> (cnt == $past(cnt) + W'(1)));

    // R4
    cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc) |=> $stable(cnt));
endmodule

// File: rtl/rxs_oct_acc.sv
module rxs_oct_acc #(
    parameter int LEN_W = 16,
    parameter int OCT_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              add_en,
    input  logic [LEN_W-1:0]  data_len,
    output logic [31:0]       oct_lo,
    output logic [OCT_W-33:0] oct_hi,
    output logic [31:0]       lo_nxt,
    output logic [OCT_W-33:0] hi_nxt
);
    localparam int HI_W = OCT_W - 32;

    logic [32:0]   lo_sum;
    logic [HI_W:0] hi_sum;
    logic          ovf;

    assign lo_sum = {1'b0, oct_lo} + 33'(data_len) + 33'(rxs_pkg::FCS_BYTES);
    assign hi_sum = {1'b0, oct_hi} + (HI_W+1)'(lo_sum[32]);
    assign ovf    = hi_sum[HI_W];

    always_comb begin
        lo_nxt = oct_lo;
        hi_nxt = oct_hi;
        if (add_en) begin
            if (ovf) begin
                lo_nxt = '1;
                hi_nxt = '1;
            end else begin
                lo_nxt = lo_sum[31:0];
                hi_nxt = hi_sum[HI_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oct_lo <= '0;
            oct_hi <= '0;
        end else begin
            oct_lo <= lo_nxt;
            oct_hi <= hi_nxt;
        end
    end

    // R6
    oct_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((&oct_lo) && (&oct_hi)) |=> ((&oct_lo) && (&oct_hi)));

    // R5
    oct_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (add_en && !((&oct_lo) && (&oct_hi))) |=> ({oct_hi, oct_lo} > $past({oct_hi, oct_lo})));

    // R5
    oct_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!add_en) |=> ($stable(oct_lo) && $stable(oct_hi)));
endmodule

// File: rtl/rx_len_stats.sv
module rx_len_stats
    import rxs_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int CNT_W = 32,
    parameter int OCT_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_vld,
    input  logic [LEN_W-1:0]  frm_len,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_vld,
    output logic [DATA_W-1:0] rd_data
);
    localparam int HI_W = OCT_W - 32;

    logic [NUM_BKT-1:0] bkt_hit;
    logic [CNT_W-1:0]   bkt_cnt [NUM_BKT];
    logic [CNT_W-1:0]   bkt_unused [NUM_BKT];
    logic [CNT_W-1:0]   tot_pkt;
    logic [CNT_W-1:0]   tot_pkt_nxt;
    logic [CNT_W-1:0]   good_pkt;
    logic [31:0]        oct_lo;
    logic [HI_W-1:0]    oct_hi;
    logic [31:0]        oct_lo_nxt;
    logic [HI_W-1:0]    oct_hi_nxt;
    logic [31:0]        good_lo;
    logic [HI_W-1:0]    good_hi;
    logic [DATA_W-1:0]  rd_mux;

    rxs_classify #(.LEN_W(LEN_W)) u_cls (
        .data_len (frm_len),
        .bkt_hit  (bkt_hit)
    );

    for (genvar g = 0; g < NUM_BKT; g++) begin : g_bkt
        rxs_sat_cnt #(.W(CNT_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc     (frm_vld && bkt_hit[g]),
            .cnt     (bkt_cnt[g]),
            .cnt_nxt (bkt_unused[g])
        );
    end

    rxs_sat_cnt #(.W(CNT_W)) u_tot (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (frm_vld),
        .cnt     (tot_pkt),
        .cnt_nxt (tot_pkt_nxt)
    );

    rxs_oct_acc #(.LEN_W(LEN_W), .OCT_W(OCT_W)) u_oct (
        .clk      (clk),
        .rst_n    (rst_n),
        .add_en   (frm_vld),
        .data_len (frm_len),
        .oct_lo   (oct_lo),
        .oct_hi   (oct_hi),
        .lo_nxt   (oct_lo_nxt),
        .hi_nxt   (oct_hi_nxt)
    );

    // Shadow copies load the same next values as the totals.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            good_pkt <= '0;
            good_lo  <= '0;
            good_hi  <= '0;
        end else begin
            good_pkt <= tot_pkt_nxt;
            good_lo  <= oct_lo_nxt;
            good_hi  <= oct_hi_nxt;
        end
    end

    always_comb begin
        rd_mux = '0;
        unique case (rd_addr)
            A_BKT64:    rd_mux = DATA_W'(bkt_cnt[0]);
            A_BKT127:   rd_mux = DATA_W'(bkt_cnt[1]);
            A_BKT255:   rd_mux = DATA_W'(bkt_cnt[2]);
            A_BKT511:   rd_mux = DATA_W'(bkt_cnt[3]);
            A_BKT1023:  rd_mux = DATA_W'(bkt_cnt[4]);
            A_BKTBIG:   rd_mux = DATA_W'(bkt_cnt[5]);
            A_TOTPKT:   rd_mux = DATA_W'(tot_pkt);
            A_GOODPKT:  rd_mux = DATA_W'(good_pkt);
            A_TOTOCTLO: rd_mux = oct_lo;
            A_TOTOCTHI: rd_mux = DATA_W'(oct_hi);
            A_GDOCTLO:  rd_mux = good_lo;
            A_GDOCTHI:  rd_mux = DATA_W'(good_hi);
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_vld  <= 1'b0;
            rd_data <= '0;
        end else begin
            rd_vld <= rd_en;
            if (rd_en) begin
                rd_data <= rd_mux;
            end
        end
    end

    // R1
    bin_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bkt_hit));

    // R3
    short_nobin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_vld && (frm_len < LEN_W'(60))) |=>
            ($stable(bkt_cnt[0]) && $stable(bkt_cnt[1]) && $stable(bkt_cnt[5])));

    // R4
    good_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        good_pkt == tot_pkt);

    // R8
    good_oct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (good_lo == oct_lo) && (good_hi == oct_hi));

    // R10
    rd_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_vld);

    // R10
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_vld);
endmodule

// File: tb/tb_rx_len_stats.sv
module tb_rx_len_stats;
    localparam int CLK_P = 10;
    localparam int S_LEN_W = 20;
    localparam int S_CNT_W = 4;
    localparam int S_OCT_W = 34;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frm_vld = 1'b0;
    logic [15:0] frm_len = '0;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic        rd_vld;
    logic [31:0] rd_data;

    logic               s_vld = 1'b0;
    logic [S_LEN_W-1:0] s_len = '0;
    logic               s_rd_en = 1'b0;
    logic [3:0]         s_addr = '0;
    logic               s_rd_vld;
    logic [31:0]        s_rd_data;

    int n_chk = 0;
    int n_fail = 0;

    longint unsigned exp_bkt [6];
    longint unsigned exp_tot;
    longint unsigned exp_oct;

    always #(CLK_P/2) clk = ~clk;

    rx_len_stats dut (
        .clk(clk), .rst_n(rst_n), .frm_vld(frm_vld), .frm_len(frm_len),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_vld(rd_vld), .rd_data(rd_data)
    );

    rx_len_stats #(.LEN_W(S_LEN_W), .CNT_W(S_CNT_W), .OCT_W(S_OCT_W)) dut_sat (
        .clk(clk), .rst_n(rst_n), .frm_vld(s_vld), .frm_len(s_len),
        .rd_en(s_rd_en), .rd_addr(s_addr), .rd_vld(s_rd_vld), .rd_data(s_rd_data)
    );

    task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_frame(input int len);
        int wl;
        longint unsigned add;
        wl  = len + 4;
        add = longint'(wl);
        if (wl == 64)        exp_bkt[0]++;
        else if (wl >= 1024) exp_bkt[5]++;
        else if (wl >= 512)  exp_bkt[4]++;
        else if (wl >= 256)  exp_bkt[3]++;
        else if (wl >= 128)  exp_bkt[2]++;
        else if (wl >= 65)   exp_bkt[1]++;
        exp_tot++;
        if (exp_oct + add < exp_oct) exp_oct = '1;
        else exp_oct = exp_oct + add;
    endtask

    task automatic frame(input int len);
        frm_vld = 1'b1;
        frm_len = 16'(len);
        @(negedge clk);
        frm_vld = 1'b0;
        model_frame(len);
    endtask

    task automatic rd(input int addr, output logic [31:0] data, output logic vld);
        rd_en   = 1'b1;
        rd_addr = 4'(addr);
        @(negedge clk);
        rd_en = 1'b0;
        data  = rd_data;
        vld   = rd_vld;
    endtask

    task automatic check_all(input string tag);
        logic [31:0] d;
        logic v;
        for (int i = 0; i < 6; i++) begin
            rd(i, d, v);
            check({tag, i == 0 ? " R1 bin64" : " R2 bin"}, d, exp_bkt[i]);
        end
        rd(6, d, v);  check({tag, " R4 total"}, d, exp_tot);
        check({tag, " R10 rd_vld"}, v, 1);
        rd(7, d, v);  check({tag, " R4 good"}, d, exp_tot);
        rd(8, d, v);  check({tag, " R5 oct lo"}, d, exp_oct[31:0]);
        rd(9, d, v);  check({tag, " R5 oct hi"}, d, exp_oct[63:32]);
        rd(10, d, v); check({tag, " R8 good lo"}, d, exp_oct[31:0]);
        rd(11, d, v); check({tag, " R8 good hi"}, d, exp_oct[63:32]);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        logic v;
        check("R11 rd_vld after reset", rd_vld, 0);
        check_all("R11 reset");
        @(negedge clk);
        check("R10 rd_vld low without request", rd_vld, 0);
        rd(13, d, v);
        check("R10 unmapped read", d, 0);
    endtask

    task automatic t_edges;
        int lens [13] = '{60, 61, 123, 124, 251, 252, 507, 508, 1019, 1020, 1500, 9000, 80};
        foreach (lens[i]) frame(lens[i]);
        check_all("R2 edges");
    endtask

    task automatic t_short;
        frame(0);
        frame(59);
        frame(30);
        check_all("R3 short");
        frame(60);
        check_all("R1 exact");
    endtask

    task automatic t_burst;
        frm_vld = 1'b1;
        for (int i = 0; i < 8; i++) begin
            frm_len = 16'(100 + i * 200);
            model_frame(100 + i * 200);
            @(negedge clk);
        end
        frm_vld = 1'b0;
        check_all("R9 back-to-back");
    endtask

    task automatic t_collide;
        logic [31:0] d;
        logic v;
        longint unsigned old_tot;
        old_tot = exp_tot;
        frm_vld = 1'b1;
        frm_len = 16'd200;
        rd_en   = 1'b1;
        rd_addr = 4'd6;
        @(negedge clk);
        frm_vld = 1'b0;
        rd_en   = 1'b0;
        check("R9 read with frame pre-value", rd_data, old_tot);
        model_frame(200);
        rd(6, d, v);
        check("R9 read after frame", d, exp_tot);
        rd(15, d, v);
        check("R10 unmapped top", d, 0);
    endtask

    task automatic s_rd(input int addr, output logic [31:0] data);
        s_rd_en = 1'b1;
        s_addr  = 4'(addr);
        @(negedge clk);
        s_rd_en = 1'b0;
        data    = s_rd_data;
    endtask

    task automatic t_sat;
        logic [31:0] d;
        longint unsigned oct;
        int n;
        localparam int LMAX = (1 << S_LEN_W) - 1;
        localparam longint unsigned OMAX = (64'd1 << S_OCT_W) - 1;
        n = 16383;
        s_len = S_LEN_W'(LMAX);
        s_vld = 1'b1;
        repeat (n) @(negedge clk);
        s_vld = 1'b0;
        oct = longint'(n) * longint'(LMAX + 4);
        s_rd(8, d);  check("R5 carry lo", d, oct[31:0]);
        s_rd(9, d);  check("R5 carry hi", d, oct[63:32]);
        s_rd(6, d);  check("R7 total saturated", d, 15);
        s_rd(5, d);  check("R7 bin saturated", d, 15);
        s_rd(7, d);  check("R4 good saturated", d, 15);
        s_vld = 1'b1;
        @(negedge clk);
        s_vld = 1'b0;
        s_rd(8, d);  check("R6 octet sat lo", d, OMAX[31:0]);
        s_rd(9, d);  check("R6 octet sat hi", d, OMAX[63:32]);
        s_vld = 1'b1;
        s_len = S_LEN_W'(100);
        repeat (3) @(negedge clk);
        s_vld = 1'b0;
        s_rd(8, d);  check("R6 octet held lo", d, OMAX[31:0]);
        s_rd(11, d); check("R8 good hi held", d, OMAX[63:32]);
        s_rd(6, d);  check("R7 total held", d, 15);
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        foreach (exp_bkt[i]) exp_bkt[i] = 0;
        exp_tot = 0;
        exp_oct = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_short();
        t_edges();
        t_burst();
        t_collide();
        t_sat();
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule